// File: doc/BRIEF.md
# Cascadable Dual Reload Timer

The block holds two 8-bit down-counters, a lower half and an upper half, each reloading from its own reload value when it passes zero. Each half counts either ticks from a shared prescaler (a free-running divider, tapped by a 4-bit select) or rising edges on its own external event pin. The event path has a two-flop synchronizer and a noise filter that can be switched on. The filter drops level changes shorter than two clock periods.

A mode input chains the two halves into one 16-bit timer. In chained mode the upper half counts underflows of the lower half. The lower half's run, source and prescaler settings govern the whole timer, while each half still takes its own reload value. The timer output is driven by the upper half, either as a toggle on each upper underflow or as a PWM level from a compare value. A pin multiplexer lets that output take over a general-purpose port pin.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset both counters read 0, both underflow pulses are 0, the timer output is 0, and the pin follows the port direction and data inputs.
- R2: A running half decrements once per count tick. On a tick while at 0 it loads its reload value and raises its underflow output for exactly one cycle, which gives one underflow every reload+1 ticks.
- R3: With the source set to internal (source bit 0), a prescaler select of k gives one count tick every 2^k clock cycles (k = 0 gives a tick every cycle).
- R4: With the source bit at 1, a half counts one tick per rising edge of its event pin, seen after a two-flop synchronizer.
- R5: With the filter bit at 1, an event pulse lasting one clock is not counted and a pulse lasting two or more clocks is counted. With the filter bit at 0, a one-clock pulse is counted.
- R6: With the chain bit at 1, the upper half takes one tick per lower-half underflow pulse, one cycle after that pulse.
- R7: With the chain bit at 1, the upper half's run, source and prescaler inputs have no effect, and the upper half runs under the lower half's run input.
- R8: A load strobe on a half copies that half's own reload value into its counter on the next clock. The load takes priority over counting and suppresses underflow.
- R9: A half whose run input is 0 and which gets no load holds its count.
- R10: With PWM off, the timer output toggles one cycle after each upper underflow pulse. With PWM on, the timer output is registered as (upper count < compare).
- R11: With the output enable at 1, the pin drives the timer output and its enable is 1, whatever the port direction and data are. With the enable at 0, the pin takes the port data and port direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain16 | input | 1 | 1 = chained 16-bit timer, 0 = two 8-bit timers |
| run | input | 2 | Run enable per half (bit 0 lower) |
| src_evt | input | 2 | Count source per half: 1 event pin, 0 prescaler |
| filt_en | input | 2 | Noise filter enable per event pin |
| psel_lo | input | 4 | Prescaler select, lower half |
| psel_hi | input | 4 | Prescaler select, upper half |
| load | input | 2 | Load strobe per half |
| reload_lo | input | 8 | Reload value, lower half |
| reload_hi | input | 8 | Reload value, upper half |
| pwm_on | input | 1 | PWM output mode for the upper half |
| pwm_cmp | input | 8 | PWM compare value |
| evt_pin | input | 2 | External event pins |
| out_en | input | 1 | Hand the port pin to the timer output |
| port_dir | input | 1 | Port direction when not taken over (1 = output) |
| port_dat | input | 1 | Port data when not taken over |
| cnt_lo | output | 8 | Lower half count |
| cnt_hi | output | 8 | Upper half count |
| uflow | output | 2 | One-cycle underflow pulse per half |
| tmr_out | output | 1 | Timer output |
| pin_out | output | 1 | Port pin data |
| pin_oe | output | 1 | Port pin output enable |

## Verification
The hardest condition to reach is a full 16-bit underflow with the upper half's own controls deliberately set wrong. The stimulus uses tiny reload values (1 and 2) so the cascade wraps within a few cycles. It holds the upper run low, selects the slowest upper prescale and sets the upper source to the event pin, then checks the exact cycle of the upper underflow and the toggle that follows. The noise filter is reached by driving event pulses of exactly one and exactly two clock periods, with the filter on and off.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 8;
    localparam int PSEL_W = 4;
    localparam int DIV_W  = (1 << PSEL_W) - 1;
    localparam int N_HALF = 2;

    typedef struct packed {
        logic              run;
        logic              evt;
        logic              filt;
        logic [PSEL_W-1:0] psel;
    } half_cfg_t;

    function automatic logic prescale_hit(input logic [DIV_W-1:0] div,
                                          input logic [PSEL_W-1:0] sel);
        logic [DIV_W-1:0] mask;
        mask = ~({DIV_W{1'b1}} << sel);
        return (div & mask) == mask;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int N = N_HALF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PSEL_W-1:0] sel [N],
    output logic [N-1:0]      tick
);
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    for (genvar i = 0; i < N; i++) begin : g_tap
        assign tick[i] = prescale_hit(div_q, sel[i]);
    end
endmodule

// File: rtl/tmr_evt_filter.sv
module tmr_evt_filter (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic filt_en,
    output logic rise
);
    logic s1_q, s2_q, s3_q, filt_q, prev_q;
    logic lvl;

    assign lvl  = filt_en ? filt_q : s2_q;
    assign rise = lvl & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            s3_q   <= 1'b0;
            filt_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            s3_q   <= s2_q;
            if (s2_q == s3_q) filt_q <= s2_q;
            prev_q <= lvl;
        end
    end
endmodule

// File: rtl/tmr_reload_counter.sv
module tmr_reload_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             uf
);
    logic step;
    assign step = run & tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            uf  <= 1'b0;
        end else if (load) begin
            cnt <= reload;
            uf  <= 1'b0;
        end else begin
            uf <= step && (cnt == '0);
            if (step) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chain16,
    input  logic [1:0]        run,
    input  logic [1:0]        src_evt,
    input  logic [1:0]        filt_en,
    input  logic [PSEL_W-1:0] psel_lo,
    input  logic [PSEL_W-1:0] psel_hi,
    input  logic [1:0]        load,
    input  logic [CNT_W-1:0]  reload_lo,
    input  logic [CNT_W-1:0]  reload_hi,
    input  logic              pwm_on,
    input  logic [CNT_W-1:0]  pwm_cmp,
    input  logic [1:0]        evt_pin,
    input  logic              out_en,
    input  logic              port_dir,
    input  logic              port_dat,
    output logic [CNT_W-1:0]  cnt_lo,
    output logic [CNT_W-1:0]  cnt_hi,
    output logic [1:0]        uflow,
    output logic              tmr_out,
    output logic              pin_out,
    output logic              pin_oe
);
    half_cfg_t         raw [N_HALF];
    half_cfg_t         eff [N_HALF];
    logic [PSEL_W-1:0] sel [N_HALF];
    logic [CNT_W-1:0]  rl  [N_HALF];
    logic [CNT_W-1:0]  cv  [N_HALF];
    logic [N_HALF-1:0] pre_tick, edge_w, cnt_tick, uf_w;
    logic              out_q;

    always_comb begin
        raw[0] = '{run: run[0], evt: src_evt[0], filt: filt_en[0], psel: psel_lo};
        raw[1] = '{run: run[1], evt: src_evt[1], filt: filt_en[1], psel: psel_hi};
        eff[0] = raw[0];
        eff[1] = chain16 ? raw[0] : raw[1];
        rl[0]  = reload_lo;
        rl[1]  = reload_hi;
    end

    for (genvar i = 0; i < N_HALF; i++) begin : g_sel
        assign sel[i] = eff[i].psel;
    end

    tmr_prescaler #(.N(N_HALF)) u_pre (
        .clk (clk),
        .rst (rst),
        .sel (sel),
        .tick(pre_tick)
    );

    for (genvar i = 0; i < N_HALF; i++) begin : g_half
        logic src_tick;

        tmr_evt_filter u_filt (
            .clk    (clk),
            .rst    (rst),
            .pin    (evt_pin[i]),
            .filt_en(raw[i].filt),
            .rise   (edge_w[i])
        );

        assign src_tick = eff[i].evt ? edge_w[i] : pre_tick[i];

        if (i == 0) begin : g_base
            assign cnt_tick[i] = src_tick;
        end else begin : g_casc
            assign cnt_tick[i] = chain16 ? uf_w[i-1] : src_tick;
        end

        tmr_reload_counter u_cnt (
            .clk   (clk),
            .rst   (rst),
            .tick  (cnt_tick[i]),
            .run   (eff[i].run),
            .load  (load[i]),
            .reload(rl[i]),
            .cnt   (cv[i]),
            .uf    (uf_w[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         out_q <= 1'b0;
        else if (pwm_on) out_q <= (cv[1] < pwm_cmp);
        else if (uf_w[1]) out_q <= ~out_q;
    end

    assign cnt_lo  = cv[0];
    assign cnt_hi  = cv[1];
    assign uflow   = uf_w;
    assign tmr_out = out_q;
    assign pin_out = out_en ? out_q : port_dat;
    assign pin_oe  = out_en | port_dir;
endmodule

// File: rtl/dual_reload_timer_chk.sv
module dual_reload_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       chain16,
    input logic [1:0] run,
    input logic [1:0] load,
    input logic [7:0] reload_lo,
    input logic       pwm_on,
    input logic [7:0] cnt_lo,
    input logic [1:0] uflow,
    input logic       tmr_out
);
    // R2: an underflow leaves the counter at the reload value
    p_uf_reload_r2: assert property (@(posedge clk) disable iff (rst)
        uflow[0] |-> cnt_lo == $past(reload_lo));

    // R6: chained upper underflow follows a lower underflow tick
    p_chain_r6: assert property (@(posedge clk) disable iff (rst)
        (chain16 && $past(chain16) && uflow[1]) |-> $past(uflow[0]));

    // R9: stopped lower half holds its count
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run[0]) && !$past(load[0])) |-> $stable(cnt_lo));

    // R10: toggle output moves only after an upper underflow
    p_tout_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pwm_on) && !$past(uflow[1])) |-> $stable(tmr_out));
endmodule

bind dual_reload_timer dual_reload_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .chain16  (chain16),
    .run      (run),
    .load     (load),
    .reload_lo(reload_lo),
    .pwm_on   (pwm_on),
    .cnt_lo   (cnt_lo),
    .uflow    (uflow),
    .tmr_out  (tmr_out)
);

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chain16 = 0;
    logic [1:0] run = 0, src_evt = 0, filt_en = 0, load = 0, evt_pin = 0;
    logic [3:0] psel_lo = 0, psel_hi = 0;
    logic [7:0] reload_lo = 0, reload_hi = 0, pwm_cmp = 0;
    logic       pwm_on = 0, out_en = 0, port_dir = 0, port_dat = 0;
    logic [7:0] cnt_lo, cnt_hi;
    logic [1:0] uflow;
    logic       tmr_out, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        string tag;
        string what;
        int    exp;
    } exp_t;
    exp_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    dual_reload_timer uut (
        .clk(clk), .rst(rst), .chain16(chain16), .run(run), .src_evt(src_evt),
        .filt_en(filt_en), .psel_lo(psel_lo), .psel_hi(psel_hi), .load(load),
        .reload_lo(reload_lo), .reload_hi(reload_hi), .pwm_on(pwm_on),
        .pwm_cmp(pwm_cmp), .evt_pin(evt_pin), .out_en(out_en),
        .port_dir(port_dir), .port_dat(port_dat), .cnt_lo(cnt_lo),
        .cnt_hi(cnt_hi), .uflow(uflow), .tmr_out(tmr_out),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: queue an expectation
    task automatic expect_v(input string tag, input string what, input int v);
        exp_t e;
        e.tag = tag; e.what = what; e.exp = v;
        sb.push_back(e);
    endtask

    // monitor side: compare the oldest expectation with the observed value
    task automatic observe(input int act);
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (act != e.exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", e.tag, e.what, act, e.exp);
        end
    endtask

    task automatic load_half(input int h);
        load[h] = 1'b1;
        step(1);
        load[h] = 1'b0;
    endtask

    task automatic pulse(input int h, input int hi_len);
        evt_pin[h] = 1'b1;
        step(hi_len);
        evt_pin[h] = 1'b0;
        step(6);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        expect_v("R1", "cnt_lo", 0);  observe(cnt_lo);
        expect_v("R1", "cnt_hi", 0);  observe(cnt_hi);
        expect_v("R1", "uflow", 0);   observe(uflow);
        expect_v("R1", "tmr_out", 0); observe(tmr_out);
        expect_v("R1", "pin_oe", 0);  observe(pin_oe);

        // R8 load, R2 countdown and reload
        reload_lo = 8'd3;
        load_half(0);
        expect_v("R8", "cnt_lo after load", 3); observe(cnt_lo);
        run[0] = 1'b1;
        step(4);
        expect_v("R2", "uflow lo", 1);       observe(uflow[0]);
        expect_v("R2", "cnt_lo reloaded", 3); observe(cnt_lo);
        step(1);
        expect_v("R2", "uflow one cycle", 0); observe(uflow[0]);
        expect_v("R2", "cnt_lo", 2);          observe(cnt_lo);
        run[0] = 1'b0;
        step(5);
        expect_v("R9", "cnt_lo held", 2); observe(cnt_lo);

        // R3 prescaler select 3: 8 ticks in 64 cycles
        reload_lo = 8'd100;
        load_half(0);
        psel_lo = 4'd3;
        run[0] = 1'b1;
        step(64);
        run[0] = 1'b0;
        expect_v("R3", "cnt_lo after 64 cycles", 92); observe(cnt_lo);

        // R4 event counting
        psel_lo = 4'd0;
        src_evt[0] = 1'b1;
        reload_lo = 8'd50;
        load_half(0);
        run[0] = 1'b1;
        for (int k = 0; k < 4; k++) pulse(0, 3);
        expect_v("R4", "cnt_lo after 4 edges", 46); observe(cnt_lo);

        // R5 noise filter
        filt_en[0] = 1'b1;
        step(4);
        for (int k = 0; k < 3; k++) pulse(0, 1);
        expect_v("R5", "1-clock pulses filtered", 46); observe(cnt_lo);
        for (int k = 0; k < 2; k++) pulse(0, 2);
        expect_v("R5", "2-clock pulses counted", 44); observe(cnt_lo);
        filt_en[0] = 1'b0;
        step(4);
        for (int k = 0; k < 2; k++) pulse(0, 1);
        expect_v("R5", "unfiltered 1-clock pulses", 42); observe(cnt_lo);
        run[0] = 1'b0;
        src_evt[0] = 1'b0;

        // R6/R7 chained mode with upper controls set to no effect
        chain16 = 1'b1;
        reload_lo = 8'd1;
        reload_hi = 8'd2;
        load = 2'b11;
        step(1);
        load = 2'b00;
        run[1] = 1'b0;
        psel_hi = 4'd15;
        src_evt[1] = 1'b1;
        run[0] = 1'b1;
        step(3);
        expect_v("R6", "cnt_hi after one lower underflow", 1); observe(cnt_hi);
        expect_v("R7", "upper runs from lower run", 1);        observe(cnt_hi != 2);
        step(4);
        expect_v("R6", "16-bit underflow", 1);  observe(uflow[1]);
        expect_v("R8", "cnt_hi own reload", 2); observe(cnt_hi);
        step(1);
        expect_v("R10", "toggle after underflow", 1); observe(tmr_out);
        run[0] = 1'b0;
        chain16 = 1'b0;
        src_evt[1] = 1'b0;
        psel_hi = 4'd0;

        // R10 PWM compare
        pwm_on = 1'b1;
        pwm_cmp = 8'd5;
        reload_hi = 8'd4;
        load_half(1);
        step(1);
        expect_v("R10", "pwm 4<5", 1); observe(tmr_out);
        pwm_cmp = 8'd3;
        step(2);
        expect_v("R10", "pwm 4<3", 0); observe(tmr_out);

        // R11 pin takeover
        out_en = 1'b1; port_dir = 1'b0; port_dat = 1'b1;
        #1;
        expect_v("R11", "pin_oe forced", 1);  observe(pin_oe);
        expect_v("R11", "pin_out timer", 0);  observe(pin_out);
        out_en = 1'b0; port_dir = 1'b1; port_dat = 1'b1;
        #1;
        expect_v("R11", "pin_oe port", 1);   observe(pin_oe);
        expect_v("R11", "pin_out port", 1);  observe(pin_out);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule